// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block performs one iteration of a non-restoring binary division each time it is commanded. It keeps a partial remainder, a latched divisor and three status bits: a quotient-sign bit (Q), a divisor-sign bit (M) and a quotient-bit output (T). Each step shifts the remainder left by one place and feeds the current T into the vacated bit. It then adds or subtracts the divisor. The choice between add and subtract comes from the previous Q and from M. The step then recomputes Q and T from the carry or borrow.

Software or a sequencer first issues an unsigned or a signed setup, which loads the remainder and the divisor. It then issues single steps, or a run command that performs a fixed number of back-to-back steps, one per clock. Each new T is also shifted into a quotient collection register, so a run leaves the generated bits side by side. Remainder correction and the final fix-up of a signed quotient are left to the caller.

Top module: `div_step_unit`

## Requirements
- R1: After reset the remainder, quotient collection register, Q, M, T, busy and done are all 0.
- R2: An unsigned setup loads the remainder from `remIn` and the divisor from `divisorIn`, and clears Q, M and T to 0 on the next clock edge.
- R3: A signed setup loads the remainder and divisor in the same way, sets Q to bit 31 of `remIn`, sets M to bit 31 of `divisorIn`, and sets T to Q XOR M.
- R4: A step forms the shifted value as the remainder shifted left by one with the old T in bit 0. If the old Q equals M it subtracts the divisor, otherwise it adds the divisor. All arithmetic is modulo 2^32, and the result becomes the new remainder.
- R5: After a step, Q equals the remainder's bit 31 from before the shift, XOR M, XOR the carry (add) or borrow (subtract) of that operation.
- R6: After a step, T is 1 when the new Q equals M and 0 otherwise, and the new T is shifted into bit 0 of the quotient collection register.
- R7: A run command performs STEPS (default 32) steps on consecutive clocks with busy high throughout. done is high for exactly one cycle, the cycle after the last step, when busy has already fallen.
- R8: While busy, setup, step and run commands are ignored. When idle and several commands arrive together, signed setup wins over unsigned setup, which wins over step, which wins over run.
- R9: Steps never change M or the latched divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initUnsigned | input | 1 | Unsigned setup command |
| initSigned | input | 1 | Signed setup command |
| stepReq | input | 1 | Single step command |
| runReq | input | 1 | Start a full run of STEPS steps |
| remIn | input | 32 | Initial partial remainder (dividend high word) |
| divisorIn | input | 32 | Divisor, latched at setup |
| remOut | output | 32 | Current partial remainder |
| quotOut | output | 32 | Collected T bits, newest in bit 0 |
| qFlag | output | 1 | Q status bit |
| mFlag | output | 1 | M status bit |
| tFlag | output | 1 | T status bit |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last run step |

## Verification
Two directed single steps come first. One subtraction produces no borrow and sets T. The other borrows and so sets Q. A signed setup with mixed signs then takes the add path, which separates the subtract branch from the add branch and tests the carry term of the Q rule. Random setups of both kinds follow, with random remainders and divisors, so all eight combinations of old Q, M and shifted-out bit occur. Each setup is followed by a random mix of single steps, idle cycles and full runs. A behavioural model tracks every clock, which exposes wrong branch choices, a missing T feed-in and off-by-one run lengths. Commands issued during a run and simultaneous commands test the priority and ignore rules.

// File: rtl/div_step_pkg.sv
package div_step_pkg;
  typedef struct packed {
    logic initU;
    logic initS;
    logic step;
  } dsStrobe_t;
endpackage

// File: rtl/div_step_ctrl.sv
module div_step_ctrl
  import div_step_pkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      initUnsigned,
  input  logic      initSigned,
  input  logic      stepReq,
  input  logic      runReq,
  output dsStrobe_t strobes,
  output logic      busy,
  output logic      done
);
  localparam int CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  typedef enum logic {S_IDLE, S_RUN} state_t;
  state_t state;
  logic [CW-1:0] stepCnt;
  logic startRun;

  assign busy = (state == S_RUN);

  // priority: signed setup, unsigned setup, step, run; all blocked while running
  always_comb begin
    strobes = '0;
    if (busy) begin
      strobes.step = 1'b1;
    end else if (initSigned) begin
      strobes.initS = 1'b1;
    end else if (initUnsigned) begin
      strobes.initU = 1'b1;
    end else if (stepReq) begin
      strobes.step = 1'b1;
    end
  end

  assign startRun = !busy && runReq && !initSigned && !initUnsigned && !stepReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= busy && (stepCnt == LAST);
      case (state)
        S_IDLE: if (startRun) begin
          state   <= S_RUN;
          stepCnt <= '0;
        end
        S_RUN: begin
          if (stepCnt == LAST) state <= S_IDLE;
          stepCnt <= stepCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.initU, strobes.initS, strobes.step}));

  // R7
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R7
  run_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    startRun |=> busy);

  // R8
  busy_blocks_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!strobes.initU && !strobes.initS));
endmodule

// File: rtl/div_step_dp.sv
module div_step_dp
  import div_step_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  dsStrobe_t    strobes,
  input  logic [W-1:0] remIn,
  input  logic [W-1:0] divisorIn,
  output logic [W-1:0] remOut,
  output logic [W-1:0] quotOut,
  output logic         qFlag,
  output logic         mFlag,
  output logic         tFlag
);
  logic [W-1:0] remReg, divReg, quotReg;
  logic qReg, mReg, tReg;

  logic [W-1:0] shifted;
  logic [W:0]   arith;
  logic         doSub, cout, nextQ, nextT;

  always_comb begin
    shifted = {remReg[W-2:0], tReg};
    doSub   = (qReg == mReg);
    if (doSub) arith = {1'b0, shifted} - {1'b0, divReg};
    else       arith = {1'b0, shifted} + {1'b0, divReg};
    cout  = arith[W];
    nextQ = remReg[W-1] ^ mReg ^ cout;
    nextT = (nextQ == mReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg  <= '0;
      divReg  <= '0;
      quotReg <= '0;
      qReg    <= 1'b0;
      mReg    <= 1'b0;
      tReg    <= 1'b0;
    end else if (strobes.initS) begin
      remReg <= remIn;
      divReg <= divisorIn;
      qReg   <= remIn[W-1];
      mReg   <= divisorIn[W-1];
      tReg   <= remIn[W-1] ^ divisorIn[W-1];
    end else if (strobes.initU) begin
      remReg <= remIn;
      divReg <= divisorIn;
      qReg   <= 1'b0;
      mReg   <= 1'b0;
      tReg   <= 1'b0;
    end else if (strobes.step) begin
      remReg  <= arith[W-1:0];
      qReg    <= nextQ;
      tReg    <= nextT;
      quotReg <= {quotReg[W-2:0], nextT};
    end
  end

  assign remOut  = remReg;
  assign quotOut = quotReg;
  assign qFlag   = qReg;
  assign mFlag   = mReg;
  assign tFlag   = tReg;

  // R9
  m_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> ($stable(mFlag) && $stable(divReg)));

  // R2
  uinit_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.initU |=> (!qFlag && !mFlag && !tFlag));

  // R6
  t_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (tFlag == (qFlag == mFlag)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> ($stable(remOut) && $stable(quotOut) && $stable(tFlag)));

  // R6
  quot_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (quotOut[W-1:1] == $past(quotOut[W-2:0])));
endmodule

// File: rtl/div_step_unit.sv
module div_step_unit
  import div_step_pkg::*;
#(
  parameter int W     = 32,
  parameter int STEPS = W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         initUnsigned,
  input  logic         initSigned,
  input  logic         stepReq,
  input  logic         runReq,
  input  logic [W-1:0] remIn,
  input  logic [W-1:0] divisorIn,
  output logic [W-1:0] remOut,
  output logic [W-1:0] quotOut,
  output logic         qFlag,
  output logic         mFlag,
  output logic         tFlag,
  output logic         busy,
  output logic         done
);
  dsStrobe_t strobes;

  div_step_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .initUnsigned(initUnsigned), .initSigned(initSigned),
    .stepReq(stepReq), .runReq(runReq),
    .strobes(strobes), .busy(busy), .done(done)
  );

  div_step_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .remIn(remIn), .divisorIn(divisorIn),
    .remOut(remOut), .quotOut(quotOut),
    .qFlag(qFlag), .mFlag(mFlag), .tFlag(tFlag)
  );
endmodule

// File: tb/div_step_unit_bench.sv
module div_step_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic iU = 0, iS = 0, st = 0, rn = 0;
  logic [31:0] remIn = '0, divIn = '0;
  logic [31:0] remOut, quotOut;
  logic qFlag, mFlag, tFlag, busy, done;

  int total = 0;
  int bad = 0;
  bit cmpEn = 0;

  always #10 clk = ~clk;

  div_step_unit u_div_step_unit (
    .clk(clk), .rstN(rstN),
    .initUnsigned(iU), .initSigned(iS), .stepReq(st), .runReq(rn),
    .remIn(remIn), .divisorIn(divIn),
    .remOut(remOut), .quotOut(quotOut),
    .qFlag(qFlag), .mFlag(mFlag), .tFlag(tFlag),
    .busy(busy), .done(done)
  );

  // behavioural reference
  longint mRem, mDiv, mQuot;
  bit mQ, mM, mT, mBusy, mDone;
  int mLeft;

  task automatic modelStep();
    longint sh, res;
    bit oldMsb, carry;
    oldMsb = mRem[31];
    sh = ((mRem * 2) % 64'h1_0000_0000) + longint'(mT);
    if (mQ == mM) begin
      carry = (sh < mDiv);
      res = sh - mDiv;
      if (res < 0) res = res + 64'h1_0000_0000;
    end else begin
      res = sh + mDiv;
      carry = (res >= 64'h1_0000_0000);
      if (carry) res = res - 64'h1_0000_0000;
    end
    mRem = res;
    mQ = oldMsb ^ mM ^ carry;
    mT = (mQ == mM);
    mQuot = ((mQuot * 2) % 64'h1_0000_0000) + longint'(mT);
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mRem = 0; mDiv = 0; mQuot = 0; mQ = 0; mM = 0; mT = 0;
      mBusy = 0; mDone = 0; mLeft = 0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        modelStep();
        mLeft = mLeft - 1;
        if (mLeft == 0) begin mBusy = 0; mDone = 1; end
      end else if (iS) begin
        mRem = remIn; mDiv = divIn; mQ = remIn[31]; mM = divIn[31]; mT = mQ ^ mM;
      end else if (iU) begin
        mRem = remIn; mDiv = divIn; mQ = 0; mM = 0; mT = 0;
      end else if (st) begin
        modelStep();
      end else if (rn) begin
        mBusy = 1; mLeft = 32;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpEn) begin
      check("R4 remainder", remOut, mRem[31:0]);
      check("R5 Q", {31'b0, qFlag}, {31'b0, mQ});
      check("R6 T", {31'b0, tFlag}, {31'b0, mT});
      check("R6 quotient", quotOut, mQuot[31:0]);
      check("R9 M", {31'b0, mFlag}, {31'b0, mM});
      check("R7 busy", {31'b0, busy}, {31'b0, mBusy});
      check("R7 done", {31'b0, done}, {31'b0, mDone});
    end
  end

  task automatic issue(bit u, bit s, bit p, bit r, logic [31:0] rv, logic [31:0] dv);
    @(negedge clk);
    iU = u; iS = s; st = p; rn = r; remIn = rv; divIn = dv;
    @(negedge clk);
    iU = 0; iS = 0; st = 0; rn = 0;
  endtask

  task automatic finishRun();
    int guard = 0;
    while (busy && guard < 100) begin @(negedge clk); guard++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 rem", remOut, 32'h0);
    check("R1 flags", {27'b0, qFlag, mFlag, tFlag, busy, done}, 32'h0);
    check("R1 quot", quotOut, 32'h0);
    cmpEn = 1;

    // R2 unsigned setup
    issue(1, 0, 0, 0, 32'd5, 32'd3);
    check("R2 rem", remOut, 32'd5);
    check("R2 flags", {29'b0, qFlag, mFlag, tFlag}, 32'h0);
    // R4 subtract without borrow: 10-3=7, R5 Q=0, R6 T=1
    issue(0, 0, 1, 0, 32'h0, 32'h0);
    check("R4 sub", remOut, 32'd7);
    check("R5 q no borrow", {31'b0, qFlag}, 32'h0);
    check("R6 t set", {31'b0, tFlag}, 32'h1);
    // borrow case: 1 -> sh=2, 2-3 borrows, Q=1, T=0
    issue(1, 0, 0, 0, 32'd1, 32'd3);
    issue(0, 0, 1, 0, 32'h0, 32'h0);
    check("R4 borrow rem", remOut, 32'hFFFF_FFFF);
    check("R5 q borrow", {31'b0, qFlag}, 32'h1);
    check("R6 t clr", {31'b0, tFlag}, 32'h0);

    // R3 signed setup, mixed signs
    issue(0, 1, 0, 0, 32'h8000_0000, 32'd3);
    check("R3 flags", {29'b0, qFlag, mFlag, tFlag}, 32'b101);
    // add path: sh=1 (T=1), 1+3=4, Q=1^0^0=1, T=0
    issue(0, 0, 1, 0, 32'h0, 32'h0);
    check("R4 add", remOut, 32'd4);
    check("R5 q add", {31'b0, qFlag}, 32'h1);

    // R8 simultaneous commands: signed wins
    issue(1, 1, 1, 1, 32'h0000_0001, 32'h8000_0000);
    check("R8 priority", {29'b0, qFlag, mFlag, tFlag}, 32'b011);
    check("R8 no run", {31'b0, busy}, 32'h0);

    // R7 full run, with commands during it ignored (R8)
    issue(1, 0, 0, 0, 32'h0000_1234, 32'h0000_0777);
    issue(0, 0, 0, 1, 32'h0, 32'h0);
    check("R7 busy high", {31'b0, busy}, 32'h1);
    issue(1, 1, 1, 1, 32'hDEAD_BEEF, 32'hFFFF_FFFF);
    check("R8 ignored M", {31'b0, mFlag}, 32'h0);
    finishRun();
    check("R7 done pulse", {31'b0, done}, 32'h1);
    @(negedge clk);
    check("R7 done single", {31'b0, done}, 32'h0);

    // random mixes
    for (int k = 0; k < 40; k++) begin
      logic [31:0] rv, dv;
      int n;
      rv = $urandom;
      dv = $urandom;
      if (k % 3 == 0) dv[31] = 1'b1;
      if ($urandom_range(1, 0) == 1) issue(0, 1, 0, 0, rv, dv);
      else issue(1, 0, 0, 0, rv, dv);
      n = $urandom_range(12, 1);
      for (int j = 0; j < n; j++) begin
        if ($urandom_range(3, 0) == 0) @(negedge clk);
        else issue(0, 0, 1, 0, 32'h0, 32'h0);
      end
      if (k % 4 == 0) begin
        issue(0, 0, 0, 1, 32'h0, 32'h0);
        finishRun();
        @(negedge clk);
      end
    end

    cmpEn = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule